// File: doc/BRIEF.md
# Configurable LCD Pixel Unpacker

The block sits between a frame-buffer fetch engine and the colour stages of a display pipeline. It accepts 32-bit words of packed frame-buffer data on a valid/ready input and emits one pixel per output handshake. In the narrow depths (1, 2, 4 and 8 bits per pixel) each pixel is a palette index for a separate lookup stage. In the wider depths the pixel leaves as direct colour with 8 bits per channel. A word carries an end-of-line flag, and the last pixel that word produces carries the same flag at the output.

The layout is set by a 3-bit depth code, a red/blue swap bit, two ordering bits, one for bytes within the word and one for pixels within a byte, and a 2-bit mux selector. On the base variant the mux selector reinterprets the 16-bit depth. The active layout is sampled when the first word of a line is accepted and holds until that line ends. The block also reports, without any clock, how many source bytes one line of a given pixel width occupies at the current depth.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: While reset is asserted and after its release, out_valid_o is 0 and in_ready_o is 1 until a word is accepted.
- R2: An accepted word produces exactly 32/bpp pixels, one per output handshake. The first pixel is valid in the cycle after acceptance. The next word is accepted no earlier than the handshake of the current word's last pixel.
- R3: Depth codes (mode_i) 0, 1, 2 and 3 select 1, 2, 4 and 8 bpp. The pixel is driven on out_index_o, zero-extended, with out_is_index_o=1 and out_rgb_o=0. With both ordering bits clear, pixel k is word bits [k*bpp +: bpp].
- R4: With be_byte_i=1 the four bytes of the word are reversed before extraction, so byte 3 becomes byte 0. Sub-byte pixels inside each byte keep little-endian order.
- R5: With be_pix_i=1, be_byte_i=0 and a depth under 8 bpp, pixel slots inside each byte are reversed, so the first pixel comes from the most significant slot. When both ordering bits are set, be_byte_i wins.
- R6: For direct colour, out_rgb_o = {R[23:16], G[15:8], B[7:0]} and out_is_index_o=0. A 5-bit channel is shifted left by 3, a 6-bit channel by 2 and a 4-bit channel by 4, with zero fill. When bgr_i=1, R and B are exchanged.
- R7: On the base variant (EXTENDED=0), depth code 4 takes two bytes per pixel and reads mux16_i. A value of 1 gives 5551: R bits [4:0], G bits [9:5], B bits [14:10], bit 15 ignored. A value of 3 gives 565 with R and B always exchanged. A value of 0 or 2 gives 565 with bgr_i honoured. The 565 layout is R bits [4:0], G bits [10:5], B bits [15:11].
- R8: On the extended variant (EXTENDED=1), depth code 4 is always 5551 with bgr_i honoured, and mux16_i has no effect.
- R9: Depth code 5 is 32 bpp with R bits [7:0], G bits [15:8] and B bits [23:16]. Code 6 is 16-bit 565. Code 7 is 12-bit in 16-bit containers with R bits [3:0], G bits [7:4] and B bits [11:8].
- R10: line_bytes_o is line_px_i divided by 8, 4 or 2 for codes 0, 1 and 2. It equals line_px_i for code 3, twice line_px_i for codes 4, 6 and 7, and four times line_px_i for code 5.
- R11: The layout inputs are sampled only when the first word of a line is accepted, which is the first word after reset or after a word with in_eol_i=1. Changes in mid-line have no effect until the next line.
- R12: out_eol_o is 1 only on the last pixel of a word accepted with in_eol_i=1.
- R13: While out_valid_o=1 and out_ready_i=0, the output pixel holds stable and in_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Depth code |
| bgr_i | input | 1 | Red/blue exchange |
| be_byte_i | input | 1 | Reverse the byte order within a word |
| be_pix_i | input | 1 | Reverse the pixel order within a byte |
| mux16_i | input | 2 | 16-bit format selector, base variant only |
| line_px_i | input | LINE_W | Line width in pixels |
| line_bytes_o | output | LINE_W+2 | Source bytes per line |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted |
| in_word_i | input | 32 | Packed frame-buffer word |
| in_eol_i | input | 1 | Word ends a line |
| out_valid_o | output | 1 | Pixel valid |
| out_ready_i | input | 1 | Pixel taken |
| out_is_index_o | output | 1 | Pixel is a palette index |
| out_index_o | output | 8 | Palette index |
| out_rgb_o | output | 24 | Direct colour {R,G,B} |
| out_eol_o | output | 1 | Last pixel of the line |

## Verification
The unpacking is tried with a single asymmetric word whose nibbles all differ, run through every depth and every combination of the ordering bits. A swap of slots, bytes or channels therefore changes the value seen. The 16-bit tests run all four mux values with bgr_i both low and high on the base variant, and the same word on the extended variant. These runs separate 5551 from 565 and a forced exchange from an honoured one. A layout change in mid-line, a stalled output and the line-size arithmetic at two widths cover the timing and the sizing rules.

// File: rtl/lcdu_pkg.sv
package lcdu_pkg;

  typedef struct packed {
    logic [2:0] mode;
    logic       bgr;
    logic       be_byte;
    logic       be_pix;
    logic [1:0] mux16;
  } lcdu_cfg_t;

  typedef struct packed {
    logic        is_index;
    logic [7:0]  index;
    logic [23:0] rgb;
  } lcdu_pix_t;

  // log2 of bits per pixel for a depth code
  function automatic logic [2:0] bpp_lg(input logic [2:0] mode);
    logic [2:0] lg;
    case (mode)
      3'd0, 3'd1, 3'd2, 3'd3: lg = mode;
      3'd5:                   lg = 3'd5;
      default:                lg = 3'd4;
    endcase
    return lg;
  endfunction

  // index of the final pixel in a 32-bit word
  function automatic logic [4:0] last_slot(input logic [2:0] mode);
    logic [5:0] count;
    count = 6'd32 >> bpp_lg(mode);
    return 5'(count - 6'd1);
  endfunction

  // bring pixel idx of the word down to bit 0
  function automatic logic [31:0] pick_raw(input logic [31:0] w,
                                           input lcdu_cfg_t c,
                                           input logic [4:0] idx);
    logic [2:0]  lg;
    logic [31:0] src;
    logic [4:0]  off;
    lg  = bpp_lg(c.mode);
    src = c.be_byte ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    off = 5'(idx << lg);
    if (!c.be_byte && c.be_pix && lg < 3'd3)
      off = off ^ 5'(4'd8 - (4'd1 << lg));
    return src >> off;
  endfunction

  function automatic lcdu_pix_t decode_pixel(input logic [31:0] raw,
                                             input lcdu_cfg_t c,
                                             input logic ext);
    lcdu_pix_t  p;
    logic [7:0] r, g, b;
    logic [8:0] mask;
    logic       swap, f565, f5551;
    p = '0; r = '0; g = '0; b = '0;
    swap = c.bgr; f565 = 1'b0; f5551 = 1'b0;
    mask = (9'd1 << (4'd1 << c.mode[1:0])) - 9'd1;
    case (c.mode)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        p.is_index = 1'b1;
        p.index    = raw[7:0] & mask[7:0];
      end
      3'd4: begin
        if (!ext && c.mux16 != 2'd1) begin
          f565 = 1'b1;
          if (c.mux16 == 2'd3) swap = 1'b1;
        end else begin
          f5551 = 1'b1;
        end
      end
      3'd5: begin
        r = raw[7:0]; g = raw[15:8]; b = raw[23:16];
      end
      3'd6: f565 = 1'b1;
      default: begin
        r = {raw[3:0], 4'h0}; g = {raw[7:4], 4'h0}; b = {raw[11:8], 4'h0};
      end
    endcase
    if (f565) begin
      r = {raw[4:0], 3'b000}; g = {raw[10:5], 2'b00}; b = {raw[15:11], 3'b000};
    end
    if (f5551) begin
      r = {raw[4:0], 3'b000}; g = {raw[9:5], 3'b000}; b = {raw[14:10], 3'b000};
    end
    p.rgb = swap ? {b, g, r} : {r, g, b};
    return p;
  endfunction

endpackage

// File: rtl/lcdu_line_cfg.sv
module lcdu_line_cfg
  import lcdu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lcdu_cfg_t live_i,
  input  logic      load_i,
  input  logic      eol_i,
  output lcdu_cfg_t held_o,
  output logic      at_sol_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o   <= '0;
      at_sol_o <= 1'b1;
    end else if (load_i) begin
      if (at_sol_o) held_o <= live_i;
      at_sol_o <= eol_i;
    end
  end

  // R11: layout frozen for words inside a line
  a_r11_midline_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i || !at_sol_o) |=> held_o == $past(held_o));
endmodule

// File: rtl/lcdu_word_seq.sv
module lcdu_word_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid_i,
  input  logic [31:0] in_word_i,
  input  logic        in_eol_i,
  input  logic        out_ready_i,
  input  logic [4:0]  last_idx_i,
  output logic        in_ready_o,
  output logic        load_o,
  output logic        busy_o,
  output logic [31:0] word_o,
  output logic        eol_o,
  output logic [4:0]  idx_o,
  output logic        last_pix_o
);
  logic fire;

  assign last_pix_o = (idx_o == last_idx_i);
  assign in_ready_o = !busy_o || (out_ready_i && last_pix_o);
  assign load_o     = in_valid_i && in_ready_o;
  assign fire       = busy_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      word_o <= '0;
      eol_o  <= 1'b0;
      idx_o  <= '0;
    end else if (load_o) begin
      busy_o <= 1'b1;
      word_o <= in_word_i;
      eol_o  <= in_eol_i;
      idx_o  <= '0;
    end else if (fire) begin
      if (last_pix_o) busy_o <= 1'b0;
      else            idx_o  <= idx_o + 5'd1;
    end
  end

  // R2: no new word while pixels of the current one remain
  a_r2_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !last_pix_o |-> !in_ready_o);
  // R13: a stalled pixel keeps its source
  a_r13_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !out_ready_i |=> busy_o && $stable(idx_o) && $stable(word_o));
endmodule

// File: rtl/lcdu_line_size.sv
module lcdu_line_size #(
  parameter int LINE_W = 12
) (
  input  logic [2:0]        mode_i,
  input  logic [LINE_W-1:0] px_i,
  output logic [LINE_W+1:0] bytes_o
);
  localparam int BW = LINE_W + 2;
  logic [BW-1:0] pxw;

  assign pxw = BW'(px_i);

  always_comb begin
    case (mode_i)
      3'd0:    bytes_o = pxw >> 3;
      3'd1:    bytes_o = pxw >> 2;
      3'd2:    bytes_o = pxw >> 1;
      3'd3:    bytes_o = pxw;
      3'd5:    bytes_o = pxw << 2;
      default: bytes_o = pxw << 1;
    endcase
  end

  // R10: wide depths give whole multiples of the width
  always_comb begin
    if (mode_i == 3'd5)
      a_r10_quad_aligned: assert (bytes_o[1:0] == 2'b00);
  end
endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker
  import lcdu_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int LINE_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              bgr_i,
  input  logic              be_byte_i,
  input  logic              be_pix_i,
  input  logic [1:0]        mux16_i,
  input  logic [LINE_W-1:0] line_px_i,
  output logic [LINE_W+1:0] line_bytes_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [31:0]       in_word_i,
  input  logic              in_eol_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_is_index_o,
  output logic [7:0]        out_index_o,
  output logic [23:0]       out_rgb_o,
  output logic              out_eol_o
);
  lcdu_cfg_t   live_cfg, held_cfg;
  lcdu_pix_t   pix;
  logic        load, busy, word_eol, last_pix, at_sol;
  logic [31:0] word_q;
  logic [4:0]  idx;

  assign live_cfg = '{mode: mode_i, bgr: bgr_i, be_byte: be_byte_i,
                      be_pix: be_pix_i, mux16: mux16_i};

  lcdu_line_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .live_i(live_cfg), .load_i(load),
    .eol_i(in_eol_i), .held_o(held_cfg), .at_sol_o(at_sol)
  );

  lcdu_word_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_word_i(in_word_i),
    .in_eol_i(in_eol_i), .out_ready_i(out_ready_i),
    .last_idx_i(last_slot(held_cfg.mode)), .in_ready_o(in_ready_o),
    .load_o(load), .busy_o(busy), .word_o(word_q), .eol_o(word_eol),
    .idx_o(idx), .last_pix_o(last_pix)
  );

  lcdu_line_size #(.LINE_W(LINE_W)) u_size (
    .mode_i(mode_i), .px_i(line_px_i), .bytes_o(line_bytes_o)
  );

  assign pix            = decode_pixel(pick_raw(word_q, held_cfg, idx), held_cfg, EXTENDED);
  assign out_valid_o    = busy;
  assign out_is_index_o = pix.is_index;
  assign out_index_o    = pix.index;
  assign out_rgb_o      = pix.rgb;
  assign out_eol_o      = busy && word_eol && last_pix;

  // R1: idle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid_o && in_ready_o);
  // R12: end of line only on a valid final pixel
  a_r12_eol_final: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol_o && out_ready_i |-> out_valid_o && in_ready_o);
  // R3: index pixels carry no colour
  a_r3_index_no_rgb: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_is_index_o |-> out_rgb_o == 24'h0);
endmodule

// File: tb/lcd_pixel_unpacker_bench.sv
module lcd_pixel_unpacker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic bgr = 1'b0, bb = 1'b0, bp = 1'b0;
  logic [1:0] mux = '0;
  logic [11:0] line_px = '0;
  logic [13:0] lb, lb_x;
  logic in_valid = 1'b0, in_eol = 1'b0, out_ready = 1'b1;
  logic [31:0] in_word = '0;
  logic rdy, vld, isidx, eol, rdy_x, vld_x, isidx_x, eol_x;
  logic [7:0] idxo, idxo_x;
  logic [23:0] rgb, rgb_x;
  int n_chk = 0, n_fail = 0;
  logic [2:0] e_mode; logic e_bgr, e_bb, e_bp; logic [1:0] e_mux;

  always #4 clk = ~clk;

  lcd_pixel_unpacker #(.EXTENDED(1'b0)) u_lcd_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bgr_i(bgr), .be_byte_i(bb),
    .be_pix_i(bp), .mux16_i(mux), .line_px_i(line_px), .line_bytes_o(lb),
    .in_valid_i(in_valid), .in_ready_o(rdy), .in_word_i(in_word), .in_eol_i(in_eol),
    .out_valid_o(vld), .out_ready_i(out_ready), .out_is_index_o(isidx),
    .out_index_o(idxo), .out_rgb_o(rgb), .out_eol_o(eol));

  lcd_pixel_unpacker #(.EXTENDED(1'b1)) u_lcd_pixel_unpacker_ext (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bgr_i(bgr), .be_byte_i(bb),
    .be_pix_i(bp), .mux16_i(mux), .line_px_i(line_px), .line_bytes_o(lb_x),
    .in_valid_i(in_valid), .in_ready_o(rdy_x), .in_word_i(in_word), .in_eol_i(in_eol),
    .out_valid_o(vld_x), .out_ready_i(out_ready), .out_is_index_o(isidx_x),
    .out_index_o(idxo_x), .out_rgb_o(rgb_x), .out_eol_o(eol_x));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bits_of(input logic [2:0] m);
    if (m <= 3) return 1 << m;
    if (m == 5) return 32;
    return 16;
  endfunction

  function automatic logic [31:0] field(input logic [31:0] w, input int k);
    int bpp, ppb, byt, slot;
    logic [31:0] sw;
    longint msk;
    bpp = bits_of(e_mode);
    msk = (64'd1 << bpp) - 1;
    if (bpp < 8) begin
      ppb = 8 / bpp; byt = k / ppb; slot = k % ppb;
      if (e_bb) byt = 3 - byt;
      else if (e_bp) slot = ppb - 1 - slot;
      return 32'((longint'(w) >> (byt * 8 + slot * bpp)) & msk);
    end
    sw = e_bb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    return 32'((longint'(sw) >> (k * bpp)) & msk);
  endfunction

  function automatic logic [23:0] colour(input logic [31:0] v, input bit ext);
    logic [7:0] r, g, b; bit sw, is565;
    sw = e_bgr; is565 = 0;
    case (e_mode)
      3'd4: begin
        if (ext || e_mux == 2'd1) is565 = 0;
        else begin is565 = 1; if (e_mux == 2'd3) sw = 1; end
      end
      3'd6: is565 = 1;
      default: ;
    endcase
    if (e_mode == 3'd5) begin r = v[7:0]; g = v[15:8]; b = v[23:16]; end
    else if (e_mode == 3'd7) begin r = v[3:0] * 16; g = v[7:4] * 16; b = v[11:8] * 16; end
    else if (is565) begin r = v[4:0] * 8; g = v[10:5] * 4; b = v[15:11] * 8; end
    else begin r = v[4:0] * 8; g = v[9:5] * 8; b = v[14:10] * 8; end
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  task automatic set_cfg(input logic [2:0] m, input logic c, input logic y,
                         input logic p, input logic [1:0] x);
    @(negedge clk);
    mode = m; bgr = c; bb = y; bp = p; mux = x;
    e_mode = m; e_bgr = c; e_bb = y; e_bp = p; e_mux = x;
  endtask

  // feed one word and check every pixel it yields
  task automatic run_word(input logic [31:0] w, input logic weol, input bit ext, input string tag);
    int n;
    logic [31:0] v;
    n = 32 / bits_of(e_mode);
    @(negedge clk);
    chk(rdy === 1'b1, {tag, " R1 ready"}, 32'(rdy), 1);
    in_word = w; in_eol = weol; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      v = field(w, k);
      if (ext) begin
        chk(vld_x === 1'b1, {tag, " R2 valid"}, 32'(vld_x), 1);
        chk(rgb_x === colour(v, 1), {tag, " R8 rgb"}, 32'(rgb_x), 32'(colour(v, 1)));
      end else begin
        chk(vld === 1'b1, {tag, " R2 valid"}, 32'(vld), 1);
        if (e_mode <= 3) begin
          chk(isidx === 1'b1 && idxo === v[7:0], {tag, " R3 index"}, 32'(idxo), v);
        end else begin
          chk(isidx === 1'b0 && rgb === colour(v, 0), {tag, " R6 rgb"}, 32'(rgb), 32'(colour(v, 0)));
        end
        chk(eol === (weol && k == n - 1), {tag, " R12 eol"}, 32'(eol), 32'(weol && k == n - 1));
      end
      @(negedge clk);
    end
    chk(vld === 1'b0, {tag, " R2 count"}, 32'(vld), 0);
  endtask

  localparam logic [31:0] PAT = 32'hA5C3_1E69;
  localparam logic [31:0] P16 = 32'hF81F_87E5;

  task automatic t_reset;
    #1;
    chk(vld === 1'b0, "R1 valid in reset", 32'(vld), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld === 1'b0 && rdy === 1'b1, "R1 idle after reset", {vld, rdy}, 2'b01);
  endtask

  task automatic t_index;
    for (int m = 0; m < 4; m++) begin
      set_cfg(3'(m), 0, 0, 0, 0); run_word(PAT, 1, 0, "R3 le");
      set_cfg(3'(m), 0, 1, 0, 0); run_word(PAT, 1, 0, "R4 be_byte");
      set_cfg(3'(m), 0, 0, 1, 0); run_word(PAT, 1, 0, "R5 be_pix");
      set_cfg(3'(m), 0, 1, 1, 0); run_word(PAT, 1, 0, "R5 both");
    end
  endtask

  task automatic t_sixteen;
    for (int x = 0; x < 4; x++) begin
      set_cfg(3'd4, 0, 0, 0, 2'(x)); run_word(P16, 1, 0, "R7 mux");
      set_cfg(3'd4, 1, 0, 0, 2'(x)); run_word(P16, 1, 0, "R7 mux bgr");
      set_cfg(3'd4, 1, 0, 0, 2'(x)); run_word(P16, 1, 1, "R8 ext");
      set_cfg(3'd4, 0, 0, 0, 2'(x)); run_word(P16, 1, 1, "R8 ext");
    end
    set_cfg(3'd4, 0, 1, 0, 2'd3); run_word(P16, 1, 0, "R4 16 be_byte");
  endtask

  task automatic t_wide;
    set_cfg(3'd5, 0, 0, 0, 0); run_word(PAT, 1, 0, "R9 32");
    set_cfg(3'd5, 1, 1, 0, 0); run_word(PAT, 1, 0, "R9 32 bgr be");
    set_cfg(3'd6, 0, 0, 0, 3); run_word(P16, 1, 0, "R9 565");
    set_cfg(3'd6, 1, 0, 0, 1); run_word(P16, 1, 0, "R6 565 bgr");
    set_cfg(3'd7, 0, 0, 0, 0); run_word(PAT, 1, 0, "R9 444");
    set_cfg(3'd7, 1, 0, 0, 0); run_word(PAT, 1, 0, "R6 444 bgr");
  endtask

  task automatic t_line_size;
    int exp_b [8] = '{80, 160, 320, 640, 1280, 2560, 1280, 1280};
    line_px = 12'd640;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); mode = 3'(m); #1;
      chk(lb === 14'(exp_b[m]), "R10 line bytes", 32'(lb), 32'(exp_b[m]));
    end
    @(negedge clk); mode = 3'd0; line_px = 12'd1000; #1;
    chk(lb === 14'd125, "R10 line bytes 1bpp", 32'(lb), 125);
    @(negedge clk); mode = 3'd5; line_px = 12'd4095; #1;
    chk(lb === 14'd16380, "R10 line bytes max", 32'(lb), 16380);
  endtask

  task automatic t_midline;
    set_cfg(3'd3, 0, 0, 0, 0);
    run_word(PAT, 0, 0, "R11 first word");
    @(negedge clk); mode = 3'd4; bb = 1'b1;
    run_word(32'h1234_5678, 1, 0, "R11 mid-line change ignored");
    e_mode = 3'd4; e_bb = 1'b1;
    run_word(P16, 1, 0, "R11 next line");
  endtask

  task automatic t_stall;
    set_cfg(3'd3, 0, 0, 0, 0);
    @(negedge clk);
    out_ready = 1'b0; in_word = PAT; in_eol = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk(vld === 1'b1 && idxo === 8'h69, "R13 stalled pixel", 32'(idxo), 32'h69);
      chk(rdy === 1'b0, "R13 no accept while stalled", 32'(rdy), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(idxo === 8'h1E, "R13 resume order", 32'(idxo), 32'h1E);
    repeat (3) @(negedge clk);
    chk(vld === 1'b0, "R2 drained after stall", 32'(vld), 0);
  endtask

  bit done = 0;
  initial begin
    e_mode = 0; e_bgr = 0; e_bb = 0; e_bp = 0; e_mux = 0;
    t_reset;
    t_index;
    t_sixteen;
    t_wide;
    t_line_size;
    t_midline;
    t_stall;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule